// File: doc/BRIEF.md
# Double-Buffered Parameter Bank Loader

This block keeps five independent parameter sets for a streaming datapath, each able to hold up to fifteen words. A host pushes new values through a single-word stream with a valid/ready handshake. Every frame opens with a header word that names the target set and the number of values that follow. The values land in a shadow copy of that set. The active copy, which is what the datapath reads, does not change while a frame loads.

The host copies a set from shadow to active by raising a commit request with the set number. The whole set is copied on one clock edge, so the datapath always sees either the old values or the new ones and never a mix. If a frame for the same set is still arriving, the copy waits until that frame's last word has been taken. Each set has its own read port: an element index goes in and the word comes out one cycle later, always with the same latency. Malformed frames and bad commit requests raise a sticky error flag.

Top module: `param_bank_loader`

## Requirements
- R1: After reset, `s_ready` is 1, `err` is 0, every `loaded` bit is 0, and every active and shadow element reads as zero.
- R2: A header word carries the element count in bits [4:0] and the set number in bits [7:5]. The next `count` accepted words are written, in order, to shadow elements 0 to count-1 of that set.
- R3: Active values change only on a commit swap. Loading a frame alone leaves every read result unchanged.
- R4: A commit request for set s, with s from 0 to 4, copies the whole shadow set s into active set s on the cycle after the request. `loaded[s]` goes high at the same time and stays high until reset.
- R5: Read port s returns active element `rd_idx` of set s one cycle after the index is presented. Index 15 returns zero.
- R6: A header whose set field is 5 or greater is dropped and sets `err`. The word after it is treated as a new header.
- R7: A header whose count is 0 or greater than 15 is dropped and sets `err`. No shadow element changes.
- R8: A frame shorter than 15 leaves shadow elements at and above its count with their previous values.
- R9: A commit for a set whose frame is still loading is held until that frame's last word is accepted. The swap then happens on the next cycle.
- R10: A commit request with a set number of 5 or more changes no set and sets `err`.
- R11: `err` stays set until reset.
- R12: `s_ready` is low for exactly one cycle during each swap. It is never low on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream word valid |
| s_data | input | 16 | Stream word, either a header or a value |
| s_ready | output | 1 | Stream ready, low during a swap cycle |
| commit_req | input | 1 | Commit strobe, one cycle wide |
| commit_sel | input | 3 | Set to commit |
| rd_idx | input | 20 | Element index per set, 4 bits each, set 0 in the low bits |
| rd_data | output | 80 | Registered read data per set, 16 bits each, set 0 in the low bits |
| loaded | output | 5 | Per-set flag: at least one commit has been made |
| err | output | 1 | Sticky error flag |

## Verification
The assertions assume the host keeps `s_valid` and `s_data` stable only while it waits for ready. They also assume commit strobes are one cycle wide. Nothing is assumed about how commits relate in time to frames, which is why the hold-off and ready-gap properties are written against internal state. The stimulus drives every input at the falling edge. It samples `s_ready` before each word so that no word is driven into a swap cycle. Commits are spaced so that each swap can be observed on its own.

// File: rtl/param_bank_loader.sv
module param_bank_loader #(
  parameter int NSETS = 5,
  parameter int MAXN  = 15,
  parameter int DW    = 16,
  localparam int SW   = $clog2(NSETS),
  localparam int IW   = $clog2(MAXN + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  input  logic [DW-1:0]       s_data,
  output logic                s_ready,
  input  logic                commit_req,
  input  logic [SW-1:0]       commit_sel,
  input  logic [NSETS*IW-1:0] rd_idx,
  output logic [NSETS*DW-1:0] rd_data,
  output logic [NSETS-1:0]    loaded,
  output logic                err
);
  localparam int CFW = IW + 1;

  logic [MAXN-1:0][DW-1:0] shd [NSETS];
  logic [MAXN-1:0][DW-1:0] act [NSETS];
  logic [DW-1:0]           rd_q [NSETS];
  logic                    busy, sw_q;
  logic [SW-1:0]           cur_set;
  logic [CFW-1:0]          cur_cnt;
  logic [IW-1:0]           wr_pos;
  logic [NSETS-1:0]        pend, swap_go, req_mask;

  wire [CFW-1:0] hdr_cnt = s_data[CFW-1:0];
  wire [SW-1:0]  hdr_set = s_data[CFW+SW-1:CFW];
  wire hdr_bad  = (32'(hdr_set) >= NSETS) || (hdr_cnt == '0) || (32'(hdr_cnt) > MAXN);
  wire take     = s_valid && s_ready;
  wire last_wd  = ({1'b0, wr_pos} + CFW'(1)) == cur_cnt;
  wire bad_sel  = commit_req && (32'(commit_sel) >= NSETS);

  assign s_ready = ~|swap_go;

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    assign swap_go[g]  = pend[g] && !sw_q && !(busy && cur_set == SW'(g));
    assign req_mask[g] = commit_req && commit_sel == SW'(g);
    assign rd_data[g*DW +: DW] = rd_q[g];

    a_r3_active_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |=> $stable(act[g]));
    a_r9_hold_midframe: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cur_set == SW'(g)) |=> $stable(act[g]));
    a_r4_loaded_on_swap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loaded[g]) |-> $past(!s_ready));
    a_r5_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(rd_idx[g*IW +: IW]) >= MAXN) |=> (rd_data[g*DW +: DW] == '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; sw_q <= 1'b0; err <= 1'b0;
      cur_set <= '0; cur_cnt <= '0; wr_pos <= '0;
      pend <= '0; loaded <= '0;
      for (int s = 0; s < NSETS; s++) begin
        shd[s] <= '0; act[s] <= '0; rd_q[s] <= '0;
      end
    end else begin
      sw_q <= |swap_go;
      pend <= (pend & ~swap_go) | req_mask;
      if (bad_sel || (take && !busy && hdr_bad)) err <= 1'b1;
      if (take) begin
        if (!busy) begin
          if (!hdr_bad) begin
            busy <= 1'b1; cur_set <= hdr_set; cur_cnt <= hdr_cnt; wr_pos <= '0;
          end
        end else begin
          shd[cur_set][wr_pos] <= s_data;
          wr_pos <= wr_pos + IW'(1);
          if (last_wd) busy <= 1'b0;
        end
      end
      for (int s = 0; s < NSETS; s++) begin
        if (swap_go[s]) begin
          act[s] <= shd[s];
          loaded[s] <= 1'b1;
        end
        rd_q[s] <= (32'(rd_idx[s*IW +: IW]) < MAXN) ? act[s][rd_idx[s*IW +: IW]] : '0;
      end
    end
  end

  a_r12_ready_gap: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready |=> s_ready);
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  a_r10_bad_commit: assert property (@(posedge clk) disable iff (!rst_n)
    bad_sel |=> err);
  // R7 shares this check with R6
  a_r6_bad_header: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !busy && hdr_bad) |=> (err && !busy));
endmodule

// File: tb/param_bank_loader_test.sv
module param_bank_loader_test;
  localparam int NS = 5, MX = 15, DW = 16, IW = 4;
  localparam logic [23:0] VEC [6] = '{
    {4'd0, 4'd15, 16'h0100}, {4'd1, 4'd15, 16'h0200}, {4'd2, 4'd7, 16'h0300},
    {4'd3, 4'd1, 16'h0400}, {4'd4, 4'd15, 16'h0500}, {4'd0, 4'd4, 16'h0600}};

  logic clk = 0, rst_n = 0, s_valid = 0, commit_req = 0;
  logic [DW-1:0] s_data = '0;
  logic [2:0] commit_sel = '0;
  logic [NS*IW-1:0] rd_idx = '0;
  logic [NS*DW-1:0] rd_data;
  logic [NS-1:0] loaded;
  logic s_ready, err;
  int checks = 0, errors = 0;
  int m_shd [NS][MX];
  int m_act [NS][MX];

  always #2 clk = ~clk;

  param_bank_loader uut (.clk, .rst_n, .s_valid, .s_data, .s_ready, .commit_req,
    .commit_sel, .rd_idx, .rd_data, .loaded, .err);

  task automatic chk(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    for (int s = 0; s < NS; s++) for (int i = 0; i < MX; i++) begin
      m_shd[s][i] = 0; m_act[s][i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic put(int w);
    s_valid = 1; s_data = DW'(w);
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 0;
  endtask

  task automatic frame(int s, int c, int base);
    put(s * 32 + c);
    for (int i = 0; i < c; i++) begin
      put(base + i);
      m_shd[s][i] = base + i;
    end
  endtask

  task automatic commit(int s);
    commit_req = 1; commit_sel = 3'(s);
    @(negedge clk);
    commit_req = 0;
    chk("R12 ready low in swap", int'(s_ready), 0);
    @(negedge clk);
    chk("R12 ready back high", int'(s_ready), 1);
    chk("R4 loaded set", int'(loaded[s]), 1);
    for (int i = 0; i < MX; i++) m_act[s][i] = m_shd[s][i];
  endtask

  task automatic rd(int s, int i, int exp, string req);
    rd_idx[s*IW +: IW] = IW'(i);
    @(negedge clk);
    chk(req, int'(rd_data[s*DW +: DW]), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 ready", int'(s_ready), 1);
    chk("R1 err", int'(err), 0);
    chk("R1 loaded", int'(loaded), 0);
    for (int s = 0; s < NS; s++) rd(s, 0, 0, "R1 active zero");

    // vector table: load, commit, read back each set (R2 R4 R5 R8)
    for (int v = 0; v < 6; v++) begin
      int s, c, b;
      s = int'(VEC[v][23:20]); c = int'(VEC[v][19:16]); b = int'(VEC[v][15:0]);
      frame(s, c, b);
      commit(s);
      for (int i = 0; i < MX; i++) rd(s, i, m_act[s][i], "R2 R8 readback");
      rd(s, 15, 0, "R5 index 15 zero");
    end
    chk("R11 no error on good frames", int'(err), 0);

    // R3: shadow load without commit leaves active unchanged
    frame(1, 3, 16'h0900);
    rd(1, 0, m_act[1][0], "R3 active unchanged");
    rd(1, 2, m_act[1][2], "R3 active unchanged");
    commit(1);
    rd(1, 2, 16'h0902, "R4 new value after commit");
    rd(1, 3, 16'h0203, "R8 tail kept");

    // R9: commit during same-set frame is held off
    frame(2, 0, 0); // count 0 header: R7 error path, no writes
    chk("R7 count zero sets err", int'(err), 1);
    do_reset();
    put(2 * 32 + 4);
    put(16'h0A00); put(16'h0A01);
    commit_req = 1; commit_sel = 3'd2;
    @(negedge clk);
    commit_req = 0;
    chk("R9 ready held high", int'(s_ready), 1);
    @(negedge clk);
    chk("R9 not loaded yet", int'(loaded[2]), 0);
    put(16'h0A02); put(16'h0A03);
    chk("R9 swap cycle after last word", int'(s_ready), 0);
    @(negedge clk);
    chk("R9 loaded after last word", int'(loaded[2]), 1);
    rd(2, 3, 16'h0A03, "R9 full frame visible");
    chk("R11 err clear after reset", int'(err), 0);

    // R6: bad set index dropped, next word is header
    put(6 * 32 + 2);
    chk("R6 bad set sets err", int'(err), 1);
    frame(0, 1, 16'h0B00);
    commit(0);
    rd(0, 0, 16'h0B00, "R6 next word parsed as header");
    rd(0, 1, 0, "R6 dropped frame wrote nothing");
    chk("R11 err sticky", int'(err), 1);

    // R7: oversize count
    do_reset();
    put(3 * 32 + 20);
    chk("R7 count 20 sets err", int'(err), 1);
    put(16'h0C00);
    chk("R7 stray word also header", int'(err), 1);
    commit(3);
    rd(3, 0, 0, "R7 shadow untouched");

    // R10: bad commit select
    do_reset();
    commit_req = 1; commit_sel = 3'd7;
    @(negedge clk);
    commit_req = 0;
    chk("R10 ready stays high", int'(s_ready), 1);
    @(negedge clk);
    chk("R10 err set", int'(err), 1);
    chk("R10 no set loaded", int'(loaded), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule